// File: doc/BRIEF.md
# Multiplexed Pixel Word Output Port

This block sends each conversion result of an image-sensor front end over a narrow shared data bus. A 10-bit or 12-bit word is split into an upper and a lower part. Each part is held on the 6-bit bus for two consecutive master-clock cycles, so one word takes four slots. In the 10-bit mode the lower part is left-aligned on the bus, and the two bus bits it does not use are driven to zero.

A word-valid strobe captures a new word, and a resolution select is captured with it. While the line-boundary input is high, the block releases every bus bit through a per-bit output-enable. It also abandons any word in progress, so the first word of the next line always starts at slot 0. The receiving side only needs the master clock and the known four-slot cadence to rebuild each word.

Top module: `pix_bus_serializer`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every output-enable bit is 0 and the bus value is 0.
- R2: With the line-boundary input low and no word in progress, a strobe captures the word. The cycle after the capturing edge shows slot 0. Slots 1, 2 and 3 follow on the next three cycles. Slots 0 and 1 carry the upper part, and slots 2 and 3 carry the lower part.
- R3: With the select at 1 (12-bit), the upper part is word bits 11..6 on bus bits 5..0, and the lower part is word bits 5..0 on bus bits 5..0.
- R4: With the select at 0 (10-bit), the upper part is word bits 9..4 on bus bits 5..0. The lower part is word bits 3..0 on bus bits 5..2, and bus bits 1..0 are 0.
- R5: The output-enable bits are registered. One clock edge after the line-boundary input is sampled high they are all 0, and one edge after it is sampled low they are all 1.
- R6: A strobe during slot 0, 1 or 2 is ignored. A strobe during slot 3 captures a new word, and that word's slot 0 appears on the very next cycle.
- R7: A line-boundary input sampled high abandons the word in progress and returns the slot count to 0. Strobes are ignored while it is high.
- R8: When no word is in progress, the bus value is 0.
- R9: The resolution select is captured with the word, so changing it during a word has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 12 | Conversion word (10-bit mode uses bits 9..0) |
| word_vld_i | input | 1 | Word-valid strobe |
| wide_sel_i | input | 1 | 1 = 12-bit word, 0 = 10-bit word |
| line_brk_i | input | 1 | Line-boundary signal; high releases the bus |
| bus_o | output | 6 | Bus value for the current slot |
| bus_oe_o | output | 6 | Per-bit output-enable, 1 = drive |

## Verification
Every output comes from a register, so every result is due exactly one clock edge after the inputs that cause it. A strobe sampled at an edge shows slot 0 at the next falling edge. Each later slot follows one falling edge later, and a change on the line-boundary input shows on the output-enables one edge later. The bench drives inputs on falling edges and updates its own model on rising edges from the same sampled inputs. It compares at every falling edge, so each expected value is taken in the cycle where the register has just updated. The directed cases check the slot positions of known words one falling edge at a time.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   // bus width and word widths shared by the block and its checker
   localparam int unsigned BUS_W_DEF    = 6;
   localparam int unsigned WIDE_W_DEF   = 12;
   localparam int unsigned NARROW_W_DEF = 10;
   localparam int unsigned SLOTS_DEF    = 4;

   typedef enum logic {
      HALF_UPPER = 1'b0,
      HALF_LOWER = 1'b1
   } half_e;

endpackage

// File: rtl/pbs_slot_seq.sv
module pbs_slot_seq #(
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  logic              line_brk,
   output logic              accept,
   output logic              busy,
   output logic [SLOT_W-1:0] slot
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic last;

   assign last   = (slot == LAST_SLOT);
   assign accept = vld && !line_brk && (!busy || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         slot <= '0;
      end else if (line_brk) begin
         busy <= 1'b0;
         slot <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         slot <= '0;
      end else if (busy) begin
         if (last) begin
            busy <= 1'b0;
            slot <= '0;
         end else begin
            slot <= slot + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pbs_word_hold.sv
module pbs_word_hold #(
   parameter int unsigned WIDE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WIDE_W-1:0] word_in,
   input  logic              wide_in,
   output logic [WIDE_W-1:0] word_q,
   output logic              wide_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         wide_q <= 1'b0;
      end else if (load) begin
         word_q <= word_in;
         wide_q <= wide_in;
      end
   end
endmodule

// File: rtl/pbs_half_fmt.sv
module pbs_half_fmt
   import pbs_pkg::*;
#(
   parameter int unsigned BUS_W    = 6,
   parameter int unsigned WIDE_W   = 12,
   parameter int unsigned NARROW_W = 10
) (
   input  logic [WIDE_W-1:0] word,
   input  logic              wide,
   input  half_e             half,
   input  logic              active,
   output logic [BUS_W-1:0]  bus
);
   localparam int unsigned PAD_W = 2 * BUS_W - NARROW_W;
   localparam int unsigned NLO_W = NARROW_W - BUS_W;

   logic [BUS_W-1:0] wide_hi, wide_lo, nar_hi, nar_lo, pick;

   assign wide_hi = word[WIDE_W-1 -: BUS_W];
   assign wide_lo = word[BUS_W-1:0];
   assign nar_hi  = word[NARROW_W-1 -: BUS_W];

   generate
      if (PAD_W > 0) begin : g_pad
         assign nar_lo = {word[NLO_W-1:0], {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign nar_lo = word[BUS_W-1:0];
      end
   endgenerate

   always_comb begin
      if (wide) pick = (half == HALF_UPPER) ? wide_hi : wide_lo;
      else      pick = (half == HALF_UPPER) ? nar_hi  : nar_lo;
      bus = active ? pick : '0;
   end
endmodule

// File: rtl/pix_bus_serializer.sv
module pix_bus_serializer
   import pbs_pkg::*;
#(
   parameter int unsigned BUS_W    = BUS_W_DEF,
   parameter int unsigned WIDE_W   = WIDE_W_DEF,
   parameter int unsigned NARROW_W = NARROW_W_DEF,
   parameter int unsigned SLOTS    = SLOTS_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDE_W-1:0] word_i,
   input  logic              word_vld_i,
   input  logic              wide_sel_i,
   input  logic              line_brk_i,
   output logic [BUS_W-1:0]  bus_o,
   output logic [BUS_W-1:0]  bus_oe_o
);
   localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam int unsigned HALF_SLOTS = SLOTS / 2;

   generate
      if (WIDE_W != 2 * BUS_W) begin : g_bad_wide
         $error("WIDE_W must be twice BUS_W");
      end
      if (NARROW_W <= BUS_W || NARROW_W > WIDE_W) begin : g_bad_narrow
         $error("NARROW_W must lie in (BUS_W, WIDE_W]");
      end
      if (SLOTS < 2 || (SLOTS % 2) != 0) begin : g_bad_slots
         $error("SLOTS must be even and at least 2");
      end
   endgenerate

   logic              accept;
   logic              busy_q;
   logic [SLOT_W-1:0] slot_q;
   logic [WIDE_W-1:0] word_q;
   logic              wide_q;
   logic [BUS_W-1:0]  oe_q;
   half_e             half;

   pbs_slot_seq #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (word_vld_i),
      .line_brk (line_brk_i),
      .accept   (accept),
      .busy     (busy_q),
      .slot     (slot_q)
   );

   pbs_word_hold #(.WIDE_W(WIDE_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .word_in (word_i),
      .wide_in (wide_sel_i),
      .word_q  (word_q),
      .wide_q  (wide_q)
   );

   assign half = (slot_q < SLOT_W'(HALF_SLOTS)) ? HALF_UPPER : HALF_LOWER;

   pbs_half_fmt #(.BUS_W(BUS_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_fmt (
      .word   (word_q),
      .wide   (wide_q),
      .half   (half),
      .active (busy_q),
      .bus    (bus_o)
   );

   // one enable flop per bus bit so each pad enable has its own driver
   generate
      for (genvar b = 0; b < BUS_W; b++) begin : g_oe
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oe_q[b] <= 1'b0;
            else        oe_q[b] <= !line_brk_i;
         end
      end
   endgenerate

   assign bus_oe_o = oe_q;
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
   parameter int unsigned BUS_W  = 6,
   parameter int unsigned SLOT_W = 2,
   parameter int unsigned SLOTS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_brk_i,
   input logic [BUS_W-1:0]  bus_o,
   input logic [BUS_W-1:0]  bus_oe_o,
   input logic              busy_q,
   input logic [SLOT_W-1:0] slot_q,
   input logic              wide_q
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

   // R1: reset releases the bus
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_release_r1: assert (bus_oe_o == '0 && bus_o == '0);
      end
   end

   // R2: each bus value is held for two slots
   p_pair_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !slot_q[0] && !line_brk_i) |=> $stable(bus_o));

   // R4: narrow lower part pads the two low bus bits with zero
   p_narrow_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !wide_q && slot_q[SLOT_W-1]) |-> (bus_o[1:0] == 2'b00));

   // R5: enables follow the line-boundary level one edge later
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_brk_i |=> (bus_oe_o == '0));
   p_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !line_brk_i |=> (bus_oe_o == '1));

   // R6: mid-word strobes cannot restart the slot count
   p_mid_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && slot_q != LAST && !line_brk_i) |=>
         (busy_q && slot_q == $past(slot_q) + 1'b1));

   // R7: line boundary abandons the word
   p_line_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_brk_i |=> (!busy_q && slot_q == '0));

   // R8: idle bus reads zero
   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (bus_o == '0));
endmodule

bind pix_bus_serializer pbs_chk #(
   .BUS_W (BUS_W),
   .SLOT_W(SLOT_W),
   .SLOTS (SLOTS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_brk_i (line_brk_i),
   .bus_o      (bus_o),
   .bus_oe_o   (bus_oe_o),
   .busy_q     (busy_q),
   .slot_q     (slot_q),
   .wide_q     (wide_q)
);

// File: tb/sim_pix_bus_serializer.sv
`timescale 1ns/1ps
module sim_pix_bus_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] word_i = '0;
   logic        word_vld_i = 1'b0;
   logic        wide_sel_i = 1'b0;
   logic        line_brk_i = 1'b0;
   logic [5:0]  bus_o;
   logic [5:0]  bus_oe_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   always #2 clk = ~clk;

   pix_bus_serializer u0 (
      .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_vld_i(word_vld_i),
      .wide_sel_i(wide_sel_i), .line_brk_i(line_brk_i),
      .bus_o(bus_o), .bus_oe_o(bus_oe_o)
   );

   // behavioural expectation built from the requirements
   logic        m_busy, m_wide, m_oe;
   logic [1:0]  m_slot;
   logic [11:0] m_word;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 0; m_slot <= 0; m_word <= 0; m_wide <= 0; m_oe <= 0;
      end else begin
         m_oe <= !line_brk_i;
         if (line_brk_i) begin
            m_busy <= 0; m_slot <= 0;
         end else if (word_vld_i && (!m_busy || m_slot == 2'd3)) begin
            m_busy <= 1; m_slot <= 0; m_word <= word_i; m_wide <= wide_sel_i;
         end else if (m_busy) begin
            if (m_slot == 2'd3) begin m_busy <= 0; m_slot <= 0; end
            else m_slot <= m_slot + 2'd1;
         end
      end
   end

   function automatic logic [5:0] exp_bus(input logic [11:0] w, input logic wd,
                                          input logic [1:0] s, input logic act);
      if (!act) return 6'd0;
      if (wd) return (s < 2) ? w[11:6] : w[5:0];
      return (s < 2) ? w[9:4] : {w[3:0], 2'b00};
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [5:0] got, input logic [5:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // continuous comparison against the model
   always @(negedge clk) begin
      if (mon_on && rst_n && !done) begin
         check("R5", "oe", bus_oe_o, {6{m_oe}});
         check(!m_busy ? "R8" : (m_wide ? "R3" : "R4"), "bus", bus_o,
               exp_bus(m_word, m_wide, m_slot, m_busy));
      end
   end

   task automatic strobe(input logic [11:0] w, input logic wd);
      @(negedge clk);
      word_i = w; wide_sel_i = wd; word_vld_i = 1'b1;
      @(negedge clk);
      word_vld_i = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #600000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      // R1 reset state
      #7;
      check("R1", "oe in reset", bus_oe_o, 6'h00);
      check("R1", "bus in reset", bus_o, 6'h00);
      @(negedge clk); rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R8", "idle bus", bus_o, 6'h00);
      check("R5", "oe driven", bus_oe_o, 6'h3F);

      // R2/R3 wide word 0xABC
      strobe(12'hABC, 1'b1);
      check("R2", "slot0", bus_o, 6'h2A);
      @(negedge clk); check("R3", "slot1", bus_o, 6'h2A);
      @(negedge clk); check("R3", "slot2", bus_o, 6'h3C);
      @(negedge clk); check("R2", "slot3", bus_o, 6'h3C);
      @(negedge clk); check("R8", "after word", bus_o, 6'h00);

      // R4/R9 narrow word 0x2C5, select flipped mid-word
      strobe(12'h2C5, 1'b0);
      check("R4", "slot0", bus_o, 6'h2C);
      wide_sel_i = 1'b1;
      @(negedge clk); check("R9", "slot1", bus_o, 6'h2C);
      @(negedge clk); check("R4", "slot2 pad", bus_o, 6'h14);
      @(negedge clk); check("R9", "slot3", bus_o, 6'h14);
      @(negedge clk);

      // R6 mid-word strobe ignored, slot-3 strobe back to back
      strobe(12'hFFF, 1'b1);
      @(negedge clk);
      word_i = 12'h000; word_vld_i = 1'b1;
      @(negedge clk); word_vld_i = 1'b0;
      check("R6", "ignored strobe", bus_o, 6'h3F);
      @(negedge clk);
      word_i = 12'h041; wide_sel_i = 1'b1; word_vld_i = 1'b1;
      @(negedge clk); word_vld_i = 1'b0;
      check("R6", "back-to-back slot0", bus_o, 6'h01);
      repeat (4) @(negedge clk);

      // R7 line boundary aborts a word and blocks strobes
      strobe(12'h555, 1'b1);
      line_brk_i = 1'b1;
      @(negedge clk);
      check("R7", "oe released", bus_oe_o, 6'h00);
      check("R7", "bus aborted", bus_o, 6'h00);
      word_i = 12'h777; word_vld_i = 1'b1;
      @(negedge clk); word_vld_i = 1'b0;
      check("R7", "strobe in line", bus_o, 6'h00);
      line_brk_i = 1'b0;
      @(negedge clk);
      check("R7", "oe back", bus_oe_o, 6'h3F);
      check("R7", "no word started", bus_o, 6'h00);

      // constrained random traffic
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         word_i     = 12'($urandom);
         wide_sel_i = 1'($urandom);
         word_vld_i = ($urandom % 100) < 45;
         line_brk_i = ($urandom % 100) < 4;
      end
      @(negedge clk);
      word_vld_i = 1'b0; line_brk_i = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule